// File: doc/BRIEF.md
# Debug data-bus scan chain

This block is one serial scan chain behind a JTAG-style test access port. Through it a debugger reaches a processor core's data bus, its instruction bus and two debug control flags. The TAP controller supplies a chain-select, capture, shift and update enable, along with two mux selects. With these the debugger can snapshot the buses, clock the snapshot out on TDO while it clocks new values in on TDI, and then latch the new values into holding registers that can take over the core-side paths.

The chain is 67 cells long. It holds a 32-bit data field, one reserved bit, a system-speed flag, a breakpoint/watchpoint flag and a 32-bit instruction field. The data field is bidirectional. During a core read it acts as an input cell on the read bus. During a core write it acts as an output cell on the write bus. Every register advances on the rising edge of TCK, except TDO, which is re-timed on the falling edge.

Top module: `dbg_bus_scan_chain`

## Requirements
- R1: The chain has 67 cells. Counted from the TDO end, the cells are data bits 0..31 (bit positions 0..31), the reserved cell (position 32), the speed flag (33), the breakpoint/watchpoint flag (34) and instruction bits 0..31 (positions 35..66). TDI enters at position 66.
- R2: A capture loads the data field from `core_wdata` when `core_is_write` is 1 and from `sys_rdata` when it is 0.
- R3: Each rising TCK edge with shift active moves the chain one cell toward TDO. TDO presents cell 0 from the falling edge before that rising edge, so data bit 0 is the first bit out.
- R4: A capture loads 0 into the reserved cell. A value shifted into that cell reaches no output.
- R5: A capture loads the instruction field from `sys_instr` and the two flags from `sys_speed_in` and `sys_brkwpt_in`.
- R6: An update copies the data, instruction and flag cells into holding registers. When `core_drive_sel` is 1, the core-side outputs (`core_rdata`, `core_instr`, `core_speed`, `core_brkwpt`) show the held values. When it is 0, they pass the live system inputs through.
- R7: When `sys_drive_sel` is 1, `sys_wdata` shows the held data field. When it is 0, it passes `core_wdata` through.
- R8: When `chain_sel` is 0, capture, shift and update have no effect. With `chain_sel` at 0, or with shift inactive, the chain cells keep their values and TDO is 0.
- R9: A synchronous active-high reset clears all chain cells, all holding registers and TDO.
- R10: If more than one enable is active on the same edge, capture wins over shift, and shift wins over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | This chain is the one selected |
| capture_en | input | 1 | Capture-DR step |
| shift_en | input | 1 | Shift-DR step |
| update_en | input | 1 | Update-DR step |
| core_drive_sel | input | 1 | Input cells feed the core from the holding registers |
| sys_drive_sel | input | 1 | Output cell feeds the system from the holding register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| core_is_write | input | 1 | 1 when the core is writing, 0 when it is reading |
| sys_rdata | input | 32 | Read data from the system |
| core_wdata | input | 32 | Write data from the core |
| sys_instr | input | 32 | Instruction from the system |
| sys_speed_in | input | 1 | System-speed flag from the system side |
| sys_brkwpt_in | input | 1 | Breakpoint/watchpoint flag from the system side |
| core_rdata | output | 32 | Read data toward the core |
| core_instr | output | 32 | Instruction toward the core |
| core_speed | output | 1 | System-speed flag toward the core |
| core_brkwpt | output | 1 | Breakpoint/watchpoint flag toward the core |
| sys_wdata | output | 32 | Write data toward the system |

## Verification
The bench captures in both access directions and compares the whole shifted-out word. A chain that is one cell short, or that scans out in reversed order, or that takes the wrong bus for the data field, gives a word that does not match. Every loaded pattern sets the reserved cell to 1, and a later capture must read it back as 0, so a design that stored that cell would show a 1. Pulses arrive while the chain is deselected, and enables overlap on the same edge. A design without gating would then corrupt the cells or the held values. A design with a different priority would shift or update when it should have captured or shifted.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
    parameter int DATA_W  = 32;
    parameter int INSTR_W = 32;
    localparam int FLAG_CELLS = 3;
    localparam int CHAIN_LEN  = DATA_W + INSTR_W + FLAG_CELLS;

    // Packed from the TDI end (MSB) down to the TDO end (LSB).
    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic               brkwpt;
        logic               speed;
        logic               rsvd;
        logic [DATA_W-1:0]  data;
    } chain_t;

    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic               brkwpt;
        logic               speed;
        logic [DATA_W-1:0]  data;
    } held_t;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } scan_op_e;

    function automatic scan_op_e decode_op(input logic sel, input logic cap,
                                           input logic sh, input logic upd);
        scan_op_e op;
        if (!sel)     op = OP_IDLE;
        else if (cap) op = OP_CAPTURE;
        else if (sh)  op = OP_SHIFT;
        else if (upd) op = OP_UPDATE;
        else          op = OP_IDLE;
        return op;
    endfunction

    function automatic chain_t snapshot(input logic is_write,
                                        input logic [DATA_W-1:0] rd,
                                        input logic [DATA_W-1:0] wd,
                                        input logic [INSTR_W-1:0] ins,
                                        input logic spd,
                                        input logic bw);
        chain_t c;
        c.data   = is_write ? wd : rd;
        c.rsvd   = 1'b0;
        c.speed  = spd;
        c.brkwpt = bw;
        c.instr  = ins;
        return c;
    endfunction
endpackage

// File: rtl/dbgsc_shift_reg.sv
module dbgsc_shift_reg
    import dbgsc_pkg::*;
(
    input  logic     tck,
    input  logic     rst,
    input  scan_op_e op,
    input  chain_t   cap_word,
    input  logic     tdi,
    output chain_t   cells
);
    localparam int LEN = CHAIN_LEN;

    logic [LEN-1:0] cells_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            cells_q <= '0;
        end else begin
            unique case (op)
                OP_CAPTURE: cells_q <= cap_word;
                OP_SHIFT:   cells_q <= {tdi, cells_q[LEN-1:1]};
                default:    cells_q <= cells_q;
            endcase
        end
    end

    assign cells = chain_t'(cells_q);

    // R3: the TDI bit lands in the far cell
    assert_tdi_entry_R3: assert property (@(posedge tck) disable iff (rst)
        (op == OP_SHIFT) |=> (cells_q[LEN-1] == $past(tdi)));

    // R8: cells hold unless capturing or shifting
    assert_cells_hold_R8: assert property (@(posedge tck) disable iff (rst)
        (op != OP_CAPTURE && op != OP_SHIFT) |=> $stable(cells_q));
endmodule

// File: rtl/dbgsc_hold_reg.sv
module dbgsc_hold_reg
    import dbgsc_pkg::*;
(
    input  logic     tck,
    input  logic     rst,
    input  scan_op_e op,
    input  held_t    next_val,
    output held_t    held
);
    always_ff @(posedge tck) begin
        if (rst)                  held <= '0;
        else if (op == OP_UPDATE) held <= next_val;
    end

    // R6: holding registers change only on an update
    assert_hold_stable_R6: assert property (@(posedge tck) disable iff (rst)
        (op != OP_UPDATE) |=> $stable(held));
endmodule

// File: rtl/dbgsc_cell_mux.sv
module dbgsc_cell_mux #(
    parameter int W = 1
) (
    input  logic         use_held,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] y
);
    always_comb y = use_held ? held : live;
endmodule

// File: rtl/dbgsc_tdo_stage.sv
module dbgsc_tdo_stage
    import dbgsc_pkg::*;
(
    input  logic     tck,
    input  logic     rst,
    input  scan_op_e op,
    input  logic     cell0,
    output logic     tdo
);
    always_ff @(negedge tck) begin
        if (rst)                 tdo <= 1'b0;
        else if (op == OP_SHIFT) tdo <= cell0;
        else                     tdo <= 1'b0;
    end

    // R8: TDO rests at zero outside shift
    assert_tdo_idle_R8: assert property (@(negedge tck) disable iff (rst)
        (op != OP_SHIFT) |=> (tdo == 1'b0));
endmodule

// File: rtl/dbg_bus_scan_chain.sv
module dbg_bus_scan_chain
    import dbgsc_pkg::*;
(
    input  logic               tck,
    input  logic               rst,
    input  logic               chain_sel,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               core_drive_sel,
    input  logic               sys_drive_sel,
    input  logic               tdi,
    output logic               tdo,
    input  logic               core_is_write,
    input  logic [DATA_W-1:0]  sys_rdata,
    input  logic [DATA_W-1:0]  core_wdata,
    input  logic [INSTR_W-1:0] sys_instr,
    input  logic               sys_speed_in,
    input  logic               sys_brkwpt_in,
    output logic [DATA_W-1:0]  core_rdata,
    output logic [INSTR_W-1:0] core_instr,
    output logic               core_speed,
    output logic               core_brkwpt,
    output logic [DATA_W-1:0]  sys_wdata
);
    scan_op_e op;
    chain_t   cap_word;
    chain_t   cells;
    held_t    next_held;
    held_t    held;

    always_comb op = decode_op(chain_sel, capture_en, shift_en, update_en);

    always_comb cap_word = snapshot(core_is_write, sys_rdata, core_wdata,
                                    sys_instr, sys_speed_in, sys_brkwpt_in);

    // The reserved cell has no holding register behind it.
    always_comb begin
        next_held.data   = cells.data;
        next_held.speed  = cells.speed;
        next_held.brkwpt = cells.brkwpt;
        next_held.instr  = cells.instr;
    end

    dbgsc_shift_reg u_cells (
        .tck      (tck),
        .rst      (rst),
        .op       (op),
        .cap_word (cap_word),
        .tdi      (tdi),
        .cells    (cells)
    );

    dbgsc_hold_reg u_hold (
        .tck      (tck),
        .rst      (rst),
        .op       (op),
        .next_val (next_held),
        .held     (held)
    );

    dbgsc_tdo_stage u_tdo (
        .tck   (tck),
        .rst   (rst),
        .op    (op),
        .cell0 (cells.data[0]),
        .tdo   (tdo)
    );

    dbgsc_cell_mux #(.W(DATA_W)) u_mux_rdata (
        .use_held (core_drive_sel), .live (sys_rdata),
        .held     (held.data),      .y    (core_rdata));

    dbgsc_cell_mux #(.W(INSTR_W)) u_mux_instr (
        .use_held (core_drive_sel), .live (sys_instr),
        .held     (held.instr),     .y    (core_instr));

    dbgsc_cell_mux #(.W(1)) u_mux_speed (
        .use_held (core_drive_sel), .live (sys_speed_in),
        .held     (held.speed),     .y    (core_speed));

    dbgsc_cell_mux #(.W(1)) u_mux_brkwpt (
        .use_held (core_drive_sel), .live (sys_brkwpt_in),
        .held     (held.brkwpt),    .y    (core_brkwpt));

    dbgsc_cell_mux #(.W(DATA_W)) u_mux_wdata (
        .use_held (sys_drive_sel),  .live (core_wdata),
        .held     (held.data),      .y    (sys_wdata));

    // R4: a capture leaves zero in the reserved cell
    assert_rsvd_zero_R4: assert property (@(posedge tck) disable iff (rst)
        (op == OP_CAPTURE) |=> (cells.rsvd == 1'b0));

    // R2: on a write cycle the data field follows the write bus
    assert_write_capture_R2: assert property (@(posedge tck) disable iff (rst)
        (op == OP_CAPTURE && core_is_write) |=> (cells.data == $past(core_wdata)));
endmodule

// File: tb/dbg_bus_scan_chain_tb_top.sv
module dbg_bus_scan_chain_tb_top;
    typedef struct packed {
        logic        wr;
        logic [31:0] rd;
        logic [31:0] wd;
        logic [31:0] ins;
        logic        spd;
        logic        bw;
        logic [66:0] load;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'hDEADBEEF, 32'h0BADF00D, 32'hE3A01005, 1'b1, 1'b0, 67'h4_0F0F0F0F_1234ABCD},
        '{1'b1, 32'h11111111, 32'hCAFEF00D, 32'h00000001, 1'b0, 1'b1, 67'h7_FFFFFFFF_80000001},
        '{1'b0, 32'h00000000, 32'hFFFFFFFF, 32'h80000000, 1'b1, 1'b1, 67'h0_00000001_FFFFFFFF},
        '{1'b1, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'hFFFFFFFF, 1'b0, 1'b0, 67'h2_AAAAAAAB_55555555}
    };

    logic tck = 1'b0;
    logic rst, chain_sel, capture_en, shift_en, update_en;
    logic core_drive_sel, sys_drive_sel, tdi, tdo, core_is_write;
    logic [31:0] sys_rdata, core_wdata, sys_instr, core_rdata, core_instr, sys_wdata;
    logic sys_speed_in, sys_brkwpt_in, core_speed, core_brkwpt;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 tck = ~tck;

    dbg_bus_scan_chain dut_i (
        .tck(tck), .rst(rst), .chain_sel(chain_sel), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en),
        .core_drive_sel(core_drive_sel), .sys_drive_sel(sys_drive_sel),
        .tdi(tdi), .tdo(tdo), .core_is_write(core_is_write),
        .sys_rdata(sys_rdata), .core_wdata(core_wdata), .sys_instr(sys_instr),
        .sys_speed_in(sys_speed_in), .sys_brkwpt_in(sys_brkwpt_in),
        .core_rdata(core_rdata), .core_instr(core_instr), .core_speed(core_speed),
        .core_brkwpt(core_brkwpt), .sys_wdata(sys_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [66:0] act,
                       input logic [66:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic do_capture();
        capture_en = 1'b1;
        step();
        capture_en = 1'b0;
    endtask

    task automatic do_update();
        update_en = 1'b1;
        step();
        update_en = 1'b0;
    endtask

    task automatic shift67(input logic [66:0] din, output logic [66:0] dout);
        for (int i = 0; i < 67; i++) begin
            tdi = din[i];
            shift_en = 1'b1;
            @(negedge tck);
            #1;
            dout[i] = tdo;
            @(posedge tck);
            #1;
        end
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [66:0] got, expw, keep;
        logic [31:0] held_data;
        rst = 1'b1; chain_sel = 1'b0; capture_en = 1'b0; shift_en = 1'b0;
        update_en = 1'b0; core_drive_sel = 1'b0; sys_drive_sel = 1'b0; tdi = 1'b0;
        core_is_write = 1'b0; sys_rdata = 32'h13572468; core_wdata = 32'h24681357;
        sys_instr = 32'h0F0F0F0F; sys_speed_in = 1'b1; sys_brkwpt_in = 1'b1;
        repeat (3) step();
        rst = 1'b0;

        // R9: reset state
        core_drive_sel = 1'b1; sys_drive_sel = 1'b1; #1;
        chk(core_rdata == 32'h0 && core_instr == 32'h0, "R9 held core-side values",
            {core_rdata, core_instr}, 67'h0);
        chk(core_speed == 1'b0 && core_brkwpt == 1'b0 && sys_wdata == 32'h0,
            "R9 held flags and write data", {core_speed, core_brkwpt, sys_wdata}, 67'h0);
        chk(tdo == 1'b0, "R9 tdo after reset", tdo, 67'h0);
        chain_sel = 1'b1;
        shift67(67'h0, got);
        chk(got == 67'h0, "R9 chain cells clear", got, 67'h0);

        // Table walk: R1 R2 R4 R5 R6 R7
        foreach (VECS[k]) begin
            core_is_write = VECS[k].wr; sys_rdata = VECS[k].rd; core_wdata = VECS[k].wd;
            sys_instr = VECS[k].ins; sys_speed_in = VECS[k].spd; sys_brkwpt_in = VECS[k].bw;
            do_capture();
            expw = {VECS[k].ins, VECS[k].bw, VECS[k].spd, 1'b0,
                    VECS[k].wr ? VECS[k].wd : VECS[k].rd};
            shift67(VECS[k].load, got);
            chk(got == expw, "R1/R2/R3/R4/R5 captured word", got, expw);
            do_update();
            core_drive_sel = 1'b1; sys_drive_sel = 1'b1; #1;
            chk(core_rdata == VECS[k].load[31:0] && core_instr == VECS[k].load[66:35],
                "R1/R6 held data and instruction", {core_rdata, core_instr},
                {VECS[k].load[31:0], VECS[k].load[66:35]});
            chk(core_speed == VECS[k].load[33] && core_brkwpt == VECS[k].load[34],
                "R1/R4/R6 held flags", {core_speed, core_brkwpt},
                {VECS[k].load[33], VECS[k].load[34]});
            chk(sys_wdata == VECS[k].load[31:0], "R7 held write data", sys_wdata,
                VECS[k].load[31:0]);
            core_drive_sel = 1'b0; sys_drive_sel = 1'b0; #1;
            chk(core_rdata == VECS[k].rd && core_instr == VECS[k].ins &&
                sys_wdata == VECS[k].wd, "R6/R7 transparent paths",
                {core_rdata, sys_wdata}, {VECS[k].rd, VECS[k].wd});
        end

        // R4: reserved 1 left from the last load must capture back as 0
        do_capture();
        shift67(67'h0, got);
        chk(got[32] == 1'b0, "R4 reserved capture", got[32], 67'h0);

        // R8: deselected chain ignores every step
        keep = 67'h5_12345678_9ABCDEF0;
        shift67(keep, got);
        held_data = VECS[NVEC-1].load[31:0];
        chain_sel = 1'b0;
        sys_rdata = 32'hFFFF0000; core_is_write = 1'b0;
        do_capture();
        shift_en = 1'b1; tdi = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge tck); #1;
            chk(tdo == 1'b0, "R8 tdo while deselected", tdo, 67'h0);
            @(posedge tck); #1;
        end
        shift_en = 1'b0; tdi = 1'b0;
        do_update();
        core_drive_sel = 1'b1; #1;
        chk(core_rdata == held_data, "R8 hold unchanged while deselected", core_rdata,
            held_data);
        chain_sel = 1'b1;
        @(negedge tck); #1;
        chk(tdo == 1'b0, "R8 tdo with shift idle", tdo, 67'h0);
        step();
        shift67(67'h0, got);
        chk(got == keep, "R8 cells kept", got, keep);

        // R10: capture beats shift
        core_is_write = 1'b0; sys_rdata = 32'h00C0FFEE; sys_instr = 32'h76543210;
        sys_speed_in = 1'b0; sys_brkwpt_in = 1'b1;
        capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
        step();
        capture_en = 1'b0; shift_en = 1'b0; tdi = 1'b0;
        expw = {32'h76543210, 1'b1, 1'b0, 1'b0, 32'h00C0FFEE};
        keep = 67'h3_00000000_0000F00F;
        shift67(keep, got);
        chk(got == expw, "R10 capture wins over shift", got, expw);

        // R10: shift beats update
        shift_en = 1'b1; update_en = 1'b1; tdi = 1'b0;
        step();
        shift_en = 1'b0; update_en = 1'b0; #1;
        chk(core_rdata == held_data, "R10 update suppressed by shift", core_rdata,
            held_data);
        do_update(); #1;
        chk(core_rdata == 32'h00007807, "R10 shift took effect", core_rdata,
            67'h00007807);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule